// File: doc/BRIEF.md
# Interrupt Status Aggregation Unit

This block keeps a 32-bit word of pending interrupt causes for a memory-mapped peripheral and turns it into an interrupt for the host. It can signal in one of two ways. In legacy mode it drives a level-sensitive line. In message mode it emits a one-cycle message pulse. Software sets bits in the word through a raise port and clears them through a separate acknowledge port. Two internal engines also set their own bits when they finish: the computation engine sets bit 0 and the DMA engine sets bit 8.

A raise event is any of these in a cycle: a software raise write, a computation-done pulse or a DMA-done pulse. When the word that results from a raise event is nonzero, message mode emits one pulse and legacy mode asserts the line. In legacy mode, an acknowledge write drops the line only when the word becomes zero. In message mode the line is left unchanged, so clearing bits never drops it. The `msg_mode` input selects the mode. Every output is registered and changes one clock after the inputs that cause it.

Top module: `irq_agg_unit`

## Requirements
- R1: While synchronous reset is high, the status word, `irq_line` and `msg_pulse` all go to zero at the next clock edge, whatever the other inputs are.
- R2: A software raise write ORs `set_data` into the status word. Bits that are already set stay set.
- R3: An acknowledge write clears every status bit that is 1 in `ack_data` and leaves the other bits unchanged.
- R4: A `calc_done` pulse sets status bit 0 and a `dma_done` pulse sets status bit 8. The two can arrive in the same cycle, together with a software raise write.
- R5: When a clear and any set arrive in the same cycle, the clear is applied first and the set second, so a bit that is both cleared and set ends up 1.
- R6: In legacy mode (`msg_mode`=0), a raise event whose resulting status is nonzero makes `irq_line` 1 on the next cycle.
- R7: In legacy mode, an acknowledge write drops `irq_line` only when the resulting status is zero. A partial clear keeps the line high.
- R8: In message mode (`msg_mode`=1), every raise event whose resulting status is nonzero gives `msg_pulse`=1 for exactly the next cycle. This holds even when bits were already pending, so raises on consecutive cycles give consecutive pulses.
- R9: In message mode, `irq_line` holds its value. An acknowledge write does not drop it, even when the status becomes zero, and a raise does not assert it.
- R10: A raise event whose resulting status is zero produces neither a pulse nor a rising line.
- R11: In a cycle with no raise event and no acknowledge write, the status word, `irq_line` and `msg_pulse`=0 stay as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_mode | input | 1 | 1 selects message pulses, 0 selects the level line |
| set_valid | input | 1 | Software raise write strobe |
| set_data | input | 32 | Bits to OR into the status word |
| ack_valid | input | 1 | Software acknowledge write strobe |
| ack_data | input | 32 | Bits to clear from the status word |
| calc_done | input | 1 | Computation engine finished; sets bit 0 |
| dma_done | input | 1 | DMA engine finished; sets bit 8 |
| status | output | 32 | Pending interrupt status word |
| irq_line | output | 1 | Level-sensitive legacy interrupt |
| msg_pulse | output | 1 | One-cycle message interrupt request |

## Verification
The bench first aims at a clear and a set that land in the same cycle. A design that applies the set before the clear would lose the new event and read back 0 for that bit. It then aims at partial acknowledges in legacy mode. A design that drops the line on any acknowledge would lose interrupts that are still pending. In message mode it checks that repeated raises on already-pending bits still pulse, which a design that detects edges would miss. It also checks that clearing to zero leaves the line alone. Finally, a long sweep with mixed modes compares every cycle against an arithmetic model of the status word. The sweep draws its data from a few bits so that the word often returns to zero.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
    localparam int unsigned STAT_W   = 32;
    localparam int unsigned NUM_SRC  = 2;
    localparam int unsigned CALC_BIT = 0;
    localparam int unsigned DMA_BIT  = 8;

    typedef logic [STAT_W-1:0] stat_t;

    typedef struct packed {
        logic  evt;
        stat_t mask;
    } set_req_t;

    typedef struct packed {
        logic  valid;
        stat_t mask;
    } clr_req_t;

    // Bit position owned by internal source number idx.
    function automatic int unsigned src_bit(int unsigned idx);
        return (idx == 0) ? CALC_BIT : DMA_BIT;
    endfunction

    // Clear first, then set.
    function automatic stat_t next_word(stat_t cur, clr_req_t c, set_req_t s);
        stat_t kill;
        kill = c.valid ? c.mask : '0;
        return (cur & ~kill) | s.mask;
    endfunction
endpackage

// File: rtl/irq_src_merge.sv
`timescale 1ns/1ps
module irq_src_merge
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_SRC = NUM_SRC
) (
    input  logic             sw_valid,
    input  stat_t            sw_data,
    input  logic [N_SRC-1:0] hw_src,
    output set_req_t         set_req
);
    stat_t src_mask [N_SRC];

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_comb begin
            src_mask[g] = '0;
            src_mask[g][src_bit(g)] = hw_src[g];
        end
    end

    always_comb begin
        stat_t acc;
        acc = sw_valid ? sw_data : '0;
        for (int i = 0; i < N_SRC; i++) begin
            acc = acc | src_mask[i];
        end
        set_req.mask = acc;
        set_req.evt  = sw_valid | (|hw_src);
    end
endmodule

// File: rtl/irq_status_reg.sv
`timescale 1ns/1ps
module irq_status_reg
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  set_req_t set_req,
    input  clr_req_t clr_req,
    output stat_t    stat_q,
    output stat_t    stat_d
);
    assign stat_d = next_word(stat_q, clr_req, set_req);

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        set_req.evt |=> ((stat_q & $past(set_req.mask)) == $past(set_req.mask))); // R2
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        clr_req.valid |=> ((stat_q & $past(clr_req.mask & ~set_req.mask)) == '0)); // R3
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!set_req.evt && !clr_req.valid) |=> $stable(stat_q)); // R11
endmodule

// File: rtl/irq_signal_gen.sv
`timescale 1ns/1ps
module irq_signal_gen
    import irq_agg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  msg_mode,
    input  logic  set_evt,
    input  logic  clr_valid,
    input  stat_t stat_d,
    output logic  irq_line,
    output logic  msg_pulse
);
    logic nz;
    assign nz = |stat_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_line  <= 1'b0;
            msg_pulse <= 1'b0;
        end else begin
            msg_pulse <= msg_mode & set_evt & nz;
            if (!msg_mode) begin
                if (set_evt && nz)          irq_line <= 1'b1;
                else if (clr_valid && !nz)  irq_line <= 1'b0;
            end
        end
    end

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        msg_pulse |-> ($past(set_evt) && $past(msg_mode))); // R8
    AST_MSG_HOLDS_LINE: assert property (@(posedge clk) disable iff (rst)
        msg_mode |=> $stable(irq_line)); // R9
    AST_FALL_ONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_line) |-> ($past(stat_d) == '0)); // R7
endmodule

// File: rtl/irq_agg_unit.sv
`timescale 1ns/1ps
module irq_agg_unit
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_mode,
    input  logic              set_valid,
    input  logic [STAT_W-1:0] set_data,
    input  logic              ack_valid,
    input  logic [STAT_W-1:0] ack_data,
    input  logic              calc_done,
    input  logic              dma_done,
    output logic [STAT_W-1:0] status,
    output logic              irq_line,
    output logic              msg_pulse
);
    set_req_t set_req;
    clr_req_t clr_req;
    stat_t    stat_d;
    logic [NUM_SRC-1:0] hw_src;

    assign hw_src        = {dma_done, calc_done};
    assign clr_req.valid = ack_valid;
    assign clr_req.mask  = ack_data;

    irq_src_merge #(.N_SRC(NUM_SRC)) u_merge (
        .sw_valid (set_valid),
        .sw_data  (set_data),
        .hw_src   (hw_src),
        .set_req  (set_req)
    );

    irq_status_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_req (set_req),
        .clr_req (clr_req),
        .stat_q  (status),
        .stat_d  (stat_d)
    );

    irq_signal_gen u_sig (
        .clk       (clk),
        .rst       (rst),
        .msg_mode  (msg_mode),
        .set_evt   (set_req.evt),
        .clr_valid (clr_req.valid),
        .stat_d    (stat_d),
        .irq_line  (irq_line),
        .msg_pulse (msg_pulse)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (status == '0 && !irq_line && !msg_pulse)); // R1
endmodule

// File: tb/irq_agg_unit_bench.sv
`timescale 1ns/1ps
module irq_agg_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_mode = 1'b0;
    logic        set_valid = 1'b0;
    logic [31:0] set_data = '0;
    logic        ack_valid = 1'b0;
    logic [31:0] ack_data = '0;
    logic        calc_done = 1'b0;
    logic        dma_done = 1'b0;
    logic [31:0] status;
    logic        irq_line;
    logic        msg_pulse;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_st = '0;
    logic        m_line = 1'b0;
    logic        m_pulse = 1'b0;

    always #2.5 clk = ~clk;

    irq_agg_unit u_irq_agg_unit (
        .clk(clk), .rst(rst), .msg_mode(msg_mode),
        .set_valid(set_valid), .set_data(set_data),
        .ack_valid(ack_valid), .ack_data(ack_data),
        .calc_done(calc_done), .dma_done(dma_done),
        .status(status), .irq_line(irq_line), .msg_pulse(msg_pulse)
    );

    task automatic check(string tag);
        checks++;
        if (status !== m_st || irq_line !== m_line || msg_pulse !== m_pulse) begin
            errors++;
            $display("FAIL %s: status=%h line=%b pulse=%b expected status=%h line=%b pulse=%b",
                     tag, status, irq_line, msg_pulse, m_st, m_line, m_pulse);
        end
    endtask

    task automatic cyc(string tag, logic md, logic sv, logic [31:0] sd,
                       logic av, logic [31:0] ad, logic c, logic d);
        logic [31:0] nxt;
        logic evt;
        msg_mode = md; set_valid = sv; set_data = sd;
        ack_valid = av; ack_data = ad; calc_done = c; dma_done = d;
        nxt = (m_st & ~(av ? ad : 32'h0)) | (sv ? sd : 32'h0)
              | {23'h0, d, 7'h0, c};
        evt = sv | c | d;
        @(posedge clk); #1;
        m_pulse = md & evt & (nxt != 0);
        if (!md) begin
            if (evt && nxt != 0)      m_line = 1'b1;
            else if (av && nxt == 0)  m_line = 1'b0;
        end
        m_st = nxt;
        check(tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset dominates busy inputs
        set_valid = 1'b1; set_data = 32'hFFFF_FFFF; calc_done = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1");
        rst = 1'b0;

        cyc("R2", 0, 1, 32'h0000_0030, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 0, 0, 0, 0);
        cyc("R2", 0, 1, 32'h8000_0010, 0, 0, 0, 0);
        cyc("R7", 0, 0, 0, 1, 32'h0000_0010, 0, 0);
        cyc("R7", 0, 0, 0, 1, 32'h8000_0020, 0, 0);
        cyc("R4", 0, 0, 0, 0, 0, 1, 0);
        cyc("R4", 0, 0, 0, 0, 0, 0, 1);
        cyc("R4", 0, 1, 32'h0000_0004, 0, 0, 1, 1);
        cyc("R5", 0, 0, 0, 1, 32'h0000_0001, 1, 0);
        cyc("R5", 0, 1, 32'h0000_0100, 1, 32'hFFFF_FFFF, 0, 0);
        cyc("R3", 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
        cyc("R10", 0, 1, 32'h0, 0, 0, 0, 0);
        cyc("R10", 1, 1, 32'h0, 0, 0, 0, 0);
        cyc("R8", 1, 1, 32'h0000_0004, 0, 0, 0, 0);
        cyc("R8", 1, 1, 32'h0000_0004, 0, 0, 0, 0);
        cyc("R8", 1, 0, 0, 0, 0, 1, 0);
        cyc("R11", 1, 0, 0, 0, 0, 0, 0);
        cyc("R9", 1, 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
        cyc("R6", 0, 1, 32'h0000_0002, 0, 0, 0, 0);
        cyc("R9", 1, 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
        cyc("R9", 1, 1, 32'h0000_0040, 0, 0, 0, 0);
        cyc("R7", 0, 0, 0, 1, 32'h0000_0040, 0, 0);
        cyc("R11", 0, 0, 0, 0, 0, 0, 0);

        // near-exhaustive sweep over a few status bits and mixed modes
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r1, r2, r3;
            r1 = $urandom; r2 = $urandom; r3 = $urandom;
            cyc("R2", r3[0] & r3[1], r3[2] & r3[3], r1 & 32'h8000_0103,
                r3[4], r2 & 32'h8000_0103, r3[5] & r3[6], r3[7] & r3[8]);
        end

        rst = 1'b1;
        @(posedge clk); #1;
        m_st = '0; m_line = 1'b0; m_pulse = 1'b0;
        check("R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule